// File: doc/BRIEF.md
# Mode-Aware GPIO Port Controller

This block is an 8-bit general-purpose I/O port for a microcontroller with several operating modes. It holds four registers: a pin data latch, a per-pin direction mask, a port-wide pull-up enable and a reduced-drive enable. Software reaches them over a simple register bus. Writes take effect on a clock edge. Reads are combinational from the current address. Toward the pads the block gives a per-pin output enable, an output value and a pull-up request. It also gives a reduced-drive level and a flag that says whether an external bus has claimed the port.

A two-bit mode input selects the operating mode: single-chip, expanded or peripheral. In single-chip mode the port works as plain I/O. In the other modes the port carries external address and data traffic. The data and direction registers then leave the map, the block stops driving the pins and pull-ups are withheld. The reduced-drive register takes exactly one write after reset and is hidden in peripheral mode.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the direction, data, pull-up enable and reduced-drive registers are all zero. `pin_oe`, `pin_pull`, `drive_reduced` and `bus_claimed` are low in single-chip mode.
- R2: Mode is single-chip (`mode` = 0). A 1 in direction bit i (address 1) raises `pin_oe[i]` and a 0 lowers it. `pin_out` follows the data register (address 0) from the edge that writes it.
- R3: Reading address 0 in single-chip mode returns the data register bit for output bits. For input bits it returns `pin_in` as sampled through a two-flop synchronizer, so a pin change is seen after the second rising edge.
- R4: Mode is expanded (`mode` = 1) or peripheral (`mode` = 2 or 3). Then `bus_claimed` is 1 and `pin_oe` is 0. Addresses 0 and 1 read as zero and writes to them are ignored.
- R5: Mode is single-chip. Control bit 0 (address 2) is the pull-up enable. When it is set, `pin_pull[i]` is 1 for every pin whose direction bit is 0, and 0 for the others.
- R6: While the port is claimed (`mode` is not 0), `pin_pull` is all zero whatever the pull-up enable holds. The enable register stays readable at address 2.
- R7: Bit 0 of address 3 is the reduced-drive enable and drives `drive_reduced`. The first write to it after reset is stored. Every later write is ignored until the next reset.
- R8: In peripheral mode (`mode` = 2 or 3) address 3 reads as zero. A write to it there is ignored and does not use up the single allowed write.
- R9: Addresses 4 to 7 are unmapped. They read as zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 single-chip, 1 expanded, 2 or 3 peripheral |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Raw pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pull | output | 8 | Per-pin pull-up request |
| drive_reduced | output | 1 | Reduced drive level for all port outputs |
| bus_claimed | output | 1 | Port owned by the external address/data bus |

## Verification
A register write takes effect at the rising edge that samples `bus_wr`. The pad outputs decode the registers combinationally, so the bench checks them at the next falling edge. Read data is combinational from the address, so the bench sets the address at a falling edge and samples one nanosecond later. Mode changes act on the outputs and reads with no delay and are checked the same way. Pin inputs pass through two flops. The bench checks that a changed pin level is still absent after one rising edge and present after the second.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE   = 2'd0,
      MODE_EXPANDED = 2'd1,
      MODE_PERIPH   = 2'd2,
      MODE_PERIPH_B = 2'd3
   } port_mode_e;

   localparam int unsigned OFS_DATA  = 0;
   localparam int unsigned OFS_DIR   = 1;
   localparam int unsigned OFS_CTRL  = 2;
   localparam int unsigned OFS_DRIVE = 3;
   localparam int unsigned NUM_REGS  = 4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] chain_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain_q[s] <= '0;
            else if (s == 0) chain_q[s] <= raw_in;
            else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              claimed,
   input  logic              drive_visible,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic              pull_en_q,
   output logic              drive_q,
   output logic [WIDTH-1:0]  rdata
);
   logic hit_data, hit_dir, hit_ctrl, hit_drive;
   logic drive_lock_q;

   assign hit_data  = !claimed && (addr == ADDR_W'(OFS_DATA));
   assign hit_dir   = !claimed && (addr == ADDR_W'(OFS_DIR));
   assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
   assign hit_drive = drive_visible && (addr == ADDR_W'(OFS_DRIVE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q       <= '0;
         dir_q        <= '0;
         pull_en_q    <= 1'b0;
         drive_q      <= 1'b0;
         drive_lock_q <= 1'b0;
      end else if (wr) begin
         if (hit_data) data_q    <= wdata;
         if (hit_dir)  dir_q     <= wdata;
         if (hit_ctrl) pull_en_q <= wdata[0];
         if (hit_drive && !drive_lock_q) begin
            drive_q      <= wdata[0];
            drive_lock_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_data)  rdata = (dir_q & data_q) | (~dir_q & pin_sync);
      if (hit_dir)   rdata = dir_q;
      if (hit_ctrl)  rdata[0] = pull_en_q;
      if (hit_drive) rdata[0] = drive_q;
   end

   p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drive_lock_q |=> drive_lock_q);
   p_drive_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drive_lock_q |=> $stable(drive_q));
   p_dir_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (claimed && wr) |=> $stable(dir_q) && $stable(data_q));
   p_drive_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_visible |=> $stable(drive_lock_q));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             claimed,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] data_q,
   input  logic             pull_en,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_pull
);
   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_pin
         assign pin_oe[i]   = !claimed && dir_q[i];
         assign pin_out[i]  = data_q[i];
         assign pin_pull[i] = !claimed && pull_en && !dir_q[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_pull,
   output logic              drive_reduced,
   output logic              bus_claimed
);
   localparam int unsigned MIN_ADDR_W = $clog2(NUM_REGS);

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpio_mode_port: WIDTH must be 1..32");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("gpio_mode_port: ADDR_W too small for register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_mode_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   port_mode_e       mode_e;
   logic             claimed, drive_visible;
   logic [WIDTH-1:0] pin_sync, data_q, dir_q;
   logic             pull_en_q, drive_q;

   assign mode_e        = port_mode_e'(mode);
   assign claimed       = (mode_e != MODE_SINGLE);
   assign drive_visible = (mode_e == MODE_SINGLE) || (mode_e == MODE_EXPANDED);

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(pin_sync));

   gpio_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .claimed(claimed), .drive_visible(drive_visible),
      .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata), .pin_sync(pin_sync),
      .data_q(data_q), .dir_q(dir_q), .pull_en_q(pull_en_q), .drive_q(drive_q),
      .rdata(bus_rdata));

   gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
      .claimed(claimed), .dir_q(dir_q), .data_q(data_q), .pull_en(pull_en_q),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pull(pin_pull));

   assign drive_reduced = drive_q;
   assign bus_claimed   = claimed;

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (pin_oe == '0 && pin_pull == '0 && drive_reduced == 1'b0);
      end
   end

   p_claim_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_claimed |-> (pin_oe == '0));
   p_pull_inputs_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pull & pin_oe) == '0);
   p_pull_claimed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_claimed |-> (pin_pull == '0));
endmodule

// File: tb/tb_gpio_mode_port.sv
module tb_gpio_mode_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe, pin_out, pin_pull;
   logic       drive_reduced, bus_claimed;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   gpio_mode_port dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
      .pin_out(pin_out), .pin_pull(pin_pull), .drive_reduced(drive_reduced),
      .bus_claimed(bus_claimed));

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic bus_write(logic [2:0] a, logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 oe", pin_oe, 8'h00);
      check("R1 pull", pin_pull, 8'h00);
      check("R1 drive", {7'd0, drive_reduced}, 8'h00);
      check("R1 claimed", {7'd0, bus_claimed}, 8'h00);
      bus_read(3'd1, v); check("R1 dir", v, 8'h00);
      bus_read(3'd2, v); check("R1 ctrl", v, 8'h00);
   endtask

   task automatic t_direction();
      bus_write(3'd1, 8'hF0);
      check("R2 oe", pin_oe, 8'hF0);
      bus_write(3'd0, 8'hA5);
      check("R2 out", pin_out, 8'hA5);
   endtask

   task automatic t_readback();
      logic [7:0] v;
      @(negedge clk); pin_in = 8'h3C;
      @(posedge clk);
      bus_read(3'd0, v); check("R3 one edge", v, 8'hA0);
      @(posedge clk);
      @(negedge clk); #1; check("R3 two edges", bus_rdata, 8'hAC);
   endtask

   task automatic t_pull();
      bus_write(3'd2, 8'h01);
      check("R5 pull", pin_pull, 8'h0F);
      bus_write(3'd1, 8'h03);
      check("R5 pull after dir", pin_pull, 8'hFC);
      bus_write(3'd1, 8'hF0);
   endtask

   task automatic t_claimed();
      logic [7:0] v;
      @(negedge clk); mode = 2'd1; #1;
      check("R4 claimed", {7'd0, bus_claimed}, 8'h01);
      check("R4 oe", pin_oe, 8'h00);
      check("R6 pull", pin_pull, 8'h00);
      bus_read(3'd0, v); check("R4 data hidden", v, 8'h00);
      bus_read(3'd1, v); check("R4 dir hidden", v, 8'h00);
      bus_read(3'd2, v); check("R6 ctrl readable", v, 8'h01);
      bus_write(3'd1, 8'hFF);
      bus_write(3'd0, 8'h00);
      @(negedge clk); mode = 2'd2; #1;
      check("R6 pull periph", pin_pull, 8'h00);
      check("R4 oe periph", pin_oe, 8'h00);
      @(negedge clk); mode = 2'd0;
      bus_read(3'd1, v); check("R4 dir kept", v, 8'hF0);
      check("R4 data kept", pin_out, 8'hA5);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      bus_read(3'd5, v); check("R9 read", v, 8'h00);
      bus_write(3'd5, 8'hFF);
      bus_write(3'd6, 8'hFF);
      bus_read(3'd1, v); check("R9 dir", v, 8'hF0);
      bus_read(3'd2, v); check("R9 ctrl", v, 8'h01);
      bus_read(3'd3, v); check("R9 drive", v, 8'h00);
   endtask

   task automatic t_drive_once();
      logic [7:0] v;
      bus_write(3'd3, 8'h01);
      check("R7 first", {7'd0, drive_reduced}, 8'h01);
      bus_write(3'd3, 8'h00);
      check("R7 second ignored", {7'd0, drive_reduced}, 8'h01);
      bus_read(3'd3, v); check("R7 read", v, 8'h01);
   endtask

   task automatic t_drive_periph();
      logic [7:0] v;
      do_reset();
      @(negedge clk); mode = 2'd2;
      bus_write(3'd3, 8'h01);
      check("R8 write ignored", {7'd0, drive_reduced}, 8'h00);
      bus_read(3'd3, v); check("R8 read zero", v, 8'h00);
      @(negedge clk); mode = 2'd3;
      bus_write(3'd3, 8'h01);
      check("R8 mode3 ignored", {7'd0, drive_reduced}, 8'h00);
      @(negedge clk); mode = 2'd1;
      bus_write(3'd3, 8'h01);
      check("R8 lock unused", {7'd0, drive_reduced}, 8'h01);
   endtask

   initial begin
      #20000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_direction();
      t_readback();
      t_pull();
      t_claimed();
      t_unmapped();
      t_drive_once();
      t_drive_periph();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule